// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a single-channel SPI master controlled through two write-only registers on a one-bit address bus. A packed configuration word sets the bit order, the idle clock level, the capture edge, the number of bits per transfer, the SCLK divisor and the chip-select pattern. Writing the 32-bit data word while the core is idle latches it and starts a transfer on the following cycle. During the transfer the block drives SCLK, MOSI and the chip-select pattern, samples MISO and assembles the received word.

SCLK is the system clock divided by a programmable divisor from 2 to 257. Every bit period is split into a setup half, with SCLK at its idle level, and a hold half, with SCLK at the opposite level. When the divisor is odd, the setup half is the longer one by a single cycle. One extra bit period follows the last bit, with SCLK idle and chip select still driven, so an n-bit transfer keeps the core busy for (n+1)*div cycles. Any register write that arrives while the core is busy is dropped and sets a sticky error flag.

The received word is a stream output with a one-cycle valid and no ready. It cannot be back-pressured: `rx_data` holds its value until the next transfer ends, so a consumer that misses the valid pulse can still read the word while the core is idle.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, busy, busy_err, sclk, mosi, cs_pat and rx_valid are all 0. The configuration defaults to length 1, divisor 2, chip-select pattern 0 and all flags 0.
- R2: A write with wr_addr=0 loads the configuration word, which takes effect from the next cycle. The fields are:
  - bit 0: LSB-first.
  - bit 1: idle SCLK level.
  - bit 2: capture on the trailing edge.
  - bits [15:8]: length minus one. Only bits [12:8] are used, so the length is 1 to 32.
  - bits [23:16]: divisor minus two.
  - bits [31:24]: chip-select pattern.
- R3: A write with wr_addr=1 while idle raises busy on the next cycle. Busy then stays high for exactly (n+1)*div cycles.
- R4: In each of the first n bit periods of div cycles, SCLK holds the idle level for (div+1)/2 cycles and then the opposite level for div/2 cycles. In the final period, and whenever the core is idle, SCLK is at the idle level.
- R5: MSB-first sends data bits n-1 down to 0, and LSB-first sends bits 0 up to n-1.
  - With the capture flag clear, bit k is on MOSI for all of period k.
  - With the capture flag set, bit k appears at the start of the hold half of period k; bit 0 is also present in the setup half of period 0.
  - In the final period MOSI keeps the last bit. When the core is idle, MOSI is 0.
- R6: MISO is sampled in the last setup cycle of each bit period (capture flag clear) or in the last hold cycle (capture flag set). In MSB-first mode the bits are shifted in from bit 0 upward, so the first bit received ends at position n-1. In LSB-first mode bit k lands at position k. Bits at positions n and above are 0.
- R7: rx_valid pulses for exactly one cycle, the first idle cycle after a transfer, with rx_data holding the received word. rx_data keeps that value afterwards.
- R8: cs_pat equals the configured pattern while busy and is 0 while idle.
- R9: A write of either register while busy is dropped. The running transfer, the configuration and the data word are all unchanged.
- R10: busy_err is set by any write while busy and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = configuration, 1 = data |
| wr_data | input | 32 | Write value |
| miso | input | 1 | Serial input from the device |
| busy | output | 1 | Transfer in progress |
| busy_err | output | 1 | Sticky flag: a write arrived while busy |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output to the device |
| cs_pat | output | 8 | Chip-select pattern, driven while busy |
| rx_valid | output | 1 | One-cycle pulse: received word available |
| rx_data | output | 32 | Received word |

## Verification
A wrong divider or phase count shows up at once as an SCLK edge in the wrong cycle of the very first bit period. It also stretches or shortens busy, which the bench measures to the exact cycle. A wrong bit index or bit order appears on MOSI within the first bit, and a wrong sample point appears in rx_data one cycle after busy falls. Loss of stickiness or a write that leaks through while busy shows on busy_err at once, or in the waveform of the next transfer, which still carries the old configuration.

// File: rtl/spi_sm_pkg.sv
package spi_sm_pkg;
  // field positions inside the packed configuration word
  localparam int FLAG_LSB  = 0;
  localparam int FLAG_CPOL = 1;
  localparam int FLAG_CPHA = 2;
  localparam int LEN_LO    = 8;
  localparam int DIV_LO    = 16;
  localparam int CS_LO     = 24;

  typedef enum logic {
    ADDR_CFG  = 1'b0,
    ADDR_DATA = 1'b1
  } spi_addr_e;
endpackage

// File: rtl/spi_sm_cfg.sv
module spi_sm_cfg
  import spi_sm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CS_W   = 8,
  parameter int DIVF_W = 8,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              busy,
  output logic              start,
  output logic              busy_err,
  output logic              lsb_first,
  output logic              cpol,
  output logic              cpha,
  output logic [LEN_W:0]    len,
  output logic [DIVF_W:0]   div,
  output logic [CS_W-1:0]   cs,
  output logic [WORD_W-1:0] data
);
  localparam logic [LEN_W:0]  LEN_ONE = 1;
  localparam logic [DIVF_W:0] DIV_TWO = 2;

  logic [2:0]        flags_q;
  logic [LEN_W-1:0]  lenm1_q;
  logic [DIVF_W-1:0] divm2_q;
  logic [CS_W-1:0]   cs_q;
  logic [WORD_W-1:0] data_q;
  logic              err_q;
  logic              acc_cfg, acc_data;
  logic              unused_wr_bits;

  assign acc_cfg  = wr_en && !busy && (wr_addr == ADDR_CFG);
  assign acc_data = wr_en && !busy && (wr_addr == ADDR_DATA);
  assign start    = acc_data;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      lenm1_q <= '0;
      divm2_q <= '0;
      cs_q    <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr_en && busy) err_q <= 1'b1;
      if (acc_cfg) begin
        flags_q <= {wr_data[FLAG_CPHA], wr_data[FLAG_CPOL], wr_data[FLAG_LSB]};
        lenm1_q <= wr_data[LEN_LO +: LEN_W];
        divm2_q <= wr_data[DIV_LO +: DIVF_W];
        cs_q    <= wr_data[CS_LO +: CS_W];
      end
      if (acc_data) data_q <= wr_data;
    end
  end

  assign lsb_first = flags_q[0];
  assign cpol      = flags_q[1];
  assign cpha      = flags_q[2];
  assign len       = {1'b0, lenm1_q} + LEN_ONE;
  assign div       = {1'b0, divm2_q} + DIV_TWO;
  assign cs        = cs_q;
  assign data      = data_q;
  assign busy_err  = err_q;
endmodule

// File: rtl/spi_sm_clkgen.sv
module spi_sm_clkgen #(
  parameter int DIVF_W = 8,
  parameter int LEN_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DIVF_W:0] div,
  input  logic [LEN_W:0]  len,
  input  logic            cpha,
  output logic            busy,
  output logic            lead,
  output logic            in_hold,
  output logic            sample,
  output logic            done,
  output logic [LEN_W:0]  per
);
  localparam logic [DIVF_W:0] DIV_ONE = 1;
  localparam logic [LEN_W:0]  PER_ONE = 1;

  logic [DIVF_W:0]   cyc_q;
  logic [LEN_W:0]    per_q;
  logic              busy_q;
  logic [DIVF_W+1:0] div_p1;
  logic [DIVF_W:0]   setup_len;
  logic              last_cyc, bit_active;

  // setup half rounds up, so an odd divisor lengthens setup
  assign div_p1     = {1'b0, div} + {{(DIVF_W+1){1'b0}}, 1'b1};
  assign setup_len  = div_p1[DIVF_W+1:1];
  assign last_cyc   = (cyc_q == div - DIV_ONE);
  assign in_hold    = (cyc_q >= setup_len);
  assign bit_active = (per_q < len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
      per_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cyc_q  <= '0;
      per_q  <= '0;
    end else if (busy_q) begin
      if (last_cyc) begin
        cyc_q <= '0;
        if (per_q == len) busy_q <= 1'b0;
        else              per_q  <= per_q + PER_ONE;
      end else begin
        cyc_q <= cyc_q + DIV_ONE;
      end
    end
  end

  assign busy   = busy_q;
  assign per    = per_q;
  assign lead   = busy_q && bit_active && in_hold;
  assign done   = busy_q && last_cyc && (per_q == len);
  assign sample = busy_q && bit_active &&
                  (cpha ? last_cyc : (cyc_q == setup_len - DIV_ONE));
endmodule

// File: rtl/spi_sm_shift.sv
module spi_sm_shift #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  logic              sample,
  input  logic              done,
  input  logic              lsb_first,
  input  logic              cpha,
  input  logic              in_hold,
  input  logic [LEN_W:0]    per,
  input  logic [LEN_W:0]    len,
  input  logic [WORD_W-1:0] data,
  input  logic              miso,
  output logic              mosi,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);
  localparam logic [LEN_W:0] PER_ONE = 1;

  logic [LEN_W:0]    k, pos;
  logic [WORD_W-1:0] acc_q, rx_q;
  logic              vld_q;
  logic              unused_pos_msb;

  always_comb begin
    if (per >= len)                k = len - PER_ONE;
    else if (cpha && !in_hold)     k = (per == '0) ? '0 : per - PER_ONE;
    else                           k = per;
    pos = lsb_first ? k : (len - PER_ONE - k);
  end

  assign unused_pos_msb = pos[LEN_W];
  assign mosi = busy && data[pos[LEN_W-1:0]];

  for (genvar b = 0; b < WORD_W; b++) begin : g_rx
    localparam logic [LEN_W:0] BIDX = b;
    logic nxt;
    if (b == 0) begin : g_lo
      assign nxt = lsb_first ? ((per == BIDX) ? miso : acc_q[b]) : miso;
    end else begin : g_hi
      assign nxt = lsb_first ? ((per == BIDX) ? miso : acc_q[b]) : acc_q[b-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n || start) acc_q[b] <= 1'b0;
      else if (sample)     acc_q[b] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= done;
      if (done) rx_q <= acc_q;
    end
  end

  assign rx_valid = vld_q;
  assign rx_data  = rx_q;
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int WORD_W = 32,
  parameter int CS_W   = 8,
  parameter int DIVF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              miso,
  output logic              busy,
  output logic              busy_err,
  output logic              sclk,
  output logic              mosi,
  output logic [CS_W-1:0]   cs_pat,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);
  localparam int LEN_W = $clog2(WORD_W);

  logic              start, cfg_lsb, cfg_cpol, cfg_cpha;
  logic [LEN_W:0]    cfg_len, per;
  logic [DIVF_W:0]   cfg_div;
  logic [CS_W-1:0]   cfg_cs;
  logic [WORD_W-1:0] data;
  logic              lead, in_hold, sample, done;

  spi_sm_cfg #(.WORD_W(WORD_W), .CS_W(CS_W), .DIVF_W(DIVF_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .start(start), .busy_err(busy_err), .lsb_first(cfg_lsb),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .len(cfg_len), .div(cfg_div),
    .cs(cfg_cs), .data(data)
  );

  spi_sm_clkgen #(.DIVF_W(DIVF_W), .LEN_W(LEN_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(start), .div(cfg_div), .len(cfg_len),
    .cpha(cfg_cpha), .busy(busy), .lead(lead), .in_hold(in_hold),
    .sample(sample), .done(done), .per(per)
  );

  spi_sm_shift #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .sample(sample),
    .done(done), .lsb_first(cfg_lsb), .cpha(cfg_cpha), .in_hold(in_hold),
    .per(per), .len(cfg_len), .data(data), .miso(miso), .mosi(mosi),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  assign sclk   = cfg_cpol ^ lead;
  assign cs_pat = busy ? cfg_cs : '0;
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
  parameter int CS_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_addr,
  input logic            busy,
  input logic            busy_err,
  input logic            sclk,
  input logic [CS_W-1:0] cs_pat,
  input logic            rx_valid,
  input logic            cpol,
  input logic [CS_W-1:0] cfg_cs
);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |=> busy_err);
  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> busy_err);
  // R10
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_err) |-> $past(busy && wr_en));
  // R3
  start_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr) |=> busy);
  // R8
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_pat == '0));
  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));
  // R7
  rx_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!busy && $past(busy)));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_cs));
endmodule

bind spi_shift_master spi_shift_master_chk #(.CS_W(CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy),
  .busy_err(busy_err), .sclk(sclk), .cs_pat(cs_pat), .rx_valid(rx_valid),
  .cpol(cfg_cpol), .cfg_cs(cfg_cs)
);

// File: tb/spi_shift_master_test.sv
module spi_shift_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0, wr_addr = 0, miso = 0;
  logic [31:0] wr_data = 0;
  logic        busy, busy_err, sclk, mosi, rx_valid;
  logic [7:0]  cs_pat;
  logic [31:0] rx_data;

  int checks = 0, errors = 0;

  // bench model of the configuration
  int m_len = 1, m_div = 2;
  bit m_lsb = 0, m_cpol = 0, m_cpha = 0;
  logic [7:0]  m_cs = 0;
  logic [31:0] m_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_shift_master uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .miso(miso), .busy(busy), .busy_err(busy_err), .sclk(sclk), .mosi(mosi),
    .cs_pat(cs_pat), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic f_sclk(int i);
    int per = i / m_div, cyc = i % m_div, s = (m_div + 1) / 2;
    return m_cpol ^ ((per < m_len) && (cyc >= s));
  endfunction

  function automatic logic f_mosi(int i);
    int per = i / m_div, cyc = i % m_div, s = (m_div + 1) / 2, k, pos;
    if (per >= m_len) k = m_len - 1;
    else if (m_cpha && cyc < s) k = (per == 0) ? 0 : per - 1;
    else k = per;
    pos = m_lsb ? k : m_len - 1 - k;
    return m_data[pos];
  endfunction

  function automatic logic [31:0] f_rx(logic [31:0] p);
    logic [31:0] r = 0;
    int s = (m_div + 1) / 2;
    for (int k = 0; k < m_len; k++) begin
      int c = k * m_div + (m_cpha ? m_div - 1 : s - 1);
      if (m_lsb) r[k] = p[c % 32];
      else       r = {r[30:0], p[c % 32]};
    end
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_len = 1; m_div = 2; m_lsb = 0; m_cpol = 0; m_cpha = 0; m_cs = 0; m_data = 0;
  endtask

  // R2: packed word {cs, div-2, len field, flags}
  task automatic wr_cfg(input bit lsb, input bit cpol, input bit cpha,
                        input logic [7:0] lenf, input int dv, input logic [7:0] cs);
    logic [7:0] dvf = 8'(dv - 2);
    @(negedge clk);
    wr_en = 1; wr_addr = 0;
    wr_data = {cs, dvf, lenf, 5'd0, cpha, cpol, lsb};
    m_lsb = lsb; m_cpol = cpol; m_cpha = cpha;
    m_len = int'(lenf[4:0]) + 1; m_div = dv; m_cs = cs;
  endtask

  task automatic xfer(input logic [31:0] d, input logic [31:0] p, input int mid_at,
                      input logic mid_addr, input logic [31:0] mid_val);
    int total, bad_busy = 0, bad_sclk = 0, bad_mosi = 0, bad_cs = 0, bad_rv = 0;
    @(negedge clk);
    wr_en = 1; wr_addr = 1; wr_data = d; m_data = d;
    total = (m_len + 1) * m_div;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      wr_en = (i == mid_at); wr_addr = mid_addr; wr_data = mid_val;
      miso = p[i % 32];
      if (busy !== 1'b1) bad_busy++;
      if (sclk !== f_sclk(i)) bad_sclk++;
      if (mosi !== f_mosi(i)) bad_mosi++;
      if (cs_pat !== m_cs) bad_cs++;
      if (rx_valid !== 1'b0) bad_rv++;
    end
    @(negedge clk);
    wr_en = 0;
    chk(bad_busy == 0, "R3", "busy window", 32'(bad_busy), 0);
    chk(busy === 1'b0, "R3", "busy falls after (n+1)*div", {31'd0, busy}, 0);
    chk(bad_sclk == 0, "R4", "sclk waveform mismatches", 32'(bad_sclk), 0);
    chk(bad_mosi == 0, "R5", "mosi waveform mismatches", 32'(bad_mosi), 0);
    chk(bad_cs == 0 && cs_pat === 8'h00, "R8", "cs pattern", 32'(bad_cs), 0);
    chk(rx_valid === 1'b1 && bad_rv == 0, "R7", "rx_valid pulse", {31'd0, rx_valid}, 1);
    chk(rx_data === f_rx(p), "R6", "received word", rx_data, f_rx(p));
    chk(sclk === m_cpol && mosi === 1'b0, "R4", "idle sclk/mosi", {30'd0, sclk, mosi},
        {30'd0, m_cpol, 1'b0});
    @(negedge clk);
    chk(rx_valid === 1'b0 && rx_data === f_rx(p), "R7", "pulse ends, data held",
        {31'd0, rx_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk({busy, busy_err, sclk, mosi, rx_valid} === 5'b0 && cs_pat === 8'h00,
        "R1", "reset outputs", {busy, busy_err, sclk, mosi, rx_valid}, 0);
    // R1: default config, len 1 div 2
    xfer(32'h0000_0001, 32'hA5A5_A5A5, -1, 0, 0);
    // R2: length field upper bits ignored (0xE7 -> length 8), odd divisor
    wr_cfg(0, 0, 0, 8'hE7, 3, 8'h5A);
    xfer(32'h0000_00C3, 32'h1234_5678, -1, 0, 0);
    // R5/R6: LSB-first, trailing capture, idle high
    wr_cfg(1, 1, 1, 8'd15, 5, 8'h81);
    xfer(32'hBEEF_1A2B, 32'hF0F0_3C3C, -1, 0, 0);
    // maximum length and divisor
    wr_cfg(0, 1, 0, 8'd31, 257, 8'hFF);
    xfer(32'h8000_0001, 32'hDEAD_BEEF, -1, 0, 0);
    // random mix
    for (int t = 0; t < 24; t++) begin
      logic [31:0] d = $urandom, p = $urandom;
      logic [7:0]  lf = 8'($urandom);
      int          dv = 2 + int'($urandom % 11);
      logic [2:0]  fl = 3'($urandom);
      wr_cfg(fl[0], fl[1], fl[2], lf, dv, 8'($urandom));
      xfer(d, p, -1, 0, 0);
    end
    chk(busy_err === 1'b0, "R10", "no spurious error", {31'd0, busy_err}, 0);
    // R9/R10: config write while busy is dropped
    wr_cfg(0, 0, 1, 8'd11, 4, 8'h3C);
    xfer(32'h0000_0ABC, 32'h55AA_33CC, 7, 0, 32'hFF07_1F07);
    chk(busy_err === 1'b1, "R10", "error after busy write", {31'd0, busy_err}, 1);
    // next transfer must still use len 12, div 4, cs 3C (R9)
    xfer(32'h0000_0F0F, 32'h0F1E_2D3C, 20, 1, 32'hFFFF_FFFF);
    chk(busy_err === 1'b1, "R10", "error stays set", {31'd0, busy_err}, 1);
    do_reset();
    @(negedge clk);
    chk(busy_err === 1'b0, "R10", "reset clears error", {31'd0, busy_err}, 0);
    summary();
    $finish;
  end
endmodule